// File: doc/BRIEF.md
# Bridge Address Window Filter

This block decides, for each memory or I/O request seen by a bus-to-bus bridge, whether the bridge claims it. It holds three address windows. The memory window is always present. The I/O window and the prefetchable memory window are optional, and each is set by parameters. Software programs every window through a small configuration write port. Each window has a packed base register and a packed limit register, plus upper-half registers for the wider modes.

Each request carries a 64-bit address, a space flag (memory or I/O) and a side flag. The side flag is primary for requests that travel down the tree and secondary for requests that travel up. On the primary side the bridge claims an address that falls inside a window and forwards it downstream. On the secondary side the sense is inverted: an address inside a window belongs below the bridge and is ignored, and any other address is claimed and passed upstream. The decision appears one clock later, together with a code that names the window that matched.

Parameters select the wider modes: `IO_32` for 32-bit I/O decoding and `PF_64` for 64-bit prefetchable decoding. Two further parameters remove the optional windows entirely.

Top module: `bridge_window_filter`

## Requirements
- R1: After reset every base register holds all ones and every limit register holds zero, so no window is enabled. Primary-side requests are then never claimed, secondary-side requests are always claimed, and the window code is 0.
- R2: `claim_q` and `win_q` reflect the request presented in the previous cycle. A cycle with `req_valid` low yields `claim_q`=0 and `win_q`=0 in the next cycle, whatever the address.
- R3: On the primary side (`req_sec`=0), a valid request is claimed exactly when it matches an enabled window.
- R4: On the secondary side (`req_sec`=1), a valid request is claimed exactly when it matches no window. `win_q` still names the window that matched.
- R5: The memory window is built from the memory base and limit registers as follows. Register bits [15:4] map to address bits [31:20]. The start of the window fills address bits [19:0] with zeros and the end fills them with ones. Register bits [3:0] have no effect. An address with any of bits [63:32] set never matches. For example, base 5550h and limit 5560h cover 55500000h through 556FFFFFh.
- R6: The I/O window is built from the I/O base and limit registers. Register bits [7:4] map to address bits [15:12], which gives 4 KB granularity. Register bits [3:0] are a read-only mode field fixed by `IO_32` (0 for 16-bit, 1 for 32-bit), and writes to them have no effect.
- R7: With `IO_32`=1, the I/O upper base and limit registers supply address bits [31:16] of the window start and end.
- R8: With `IO_32`=0, the I/O upper registers are ignored. An I/O address with any of bits [31:16] set falls outside the window.
- R9: The prefetchable window uses 1 MB granularity, built in the same way as R5. With `PF_64`=1, the 32-bit upper base and limit registers supply address bits [63:32]. With `PF_64`=0, those registers are ignored and an address with any of bits [63:32] set does not match.
- R10: A window whose expanded start lies above its expanded end claims nothing. A window whose start equals its end is enabled.
- R11: Window codes are 0 for none, 1 for memory, 2 for I/O and 3 for prefetchable. I/O requests match only the I/O window. Memory requests match the memory or prefetchable window, and the memory window wins when both match.
- R12: A configuration write with `cfg_we`=1 selects a register with `cfg_sel`, using these codes:
  - 0: memory base, data[15:0]
  - 1: memory limit, data[15:0]
  - 2: I/O base, data[7:0]
  - 3: I/O limit, data[7:0]
  - 4: I/O upper base, data[15:0]
  - 5: I/O upper limit, data[15:0]
  - 6: prefetchable base, data[15:0]
  - 7: prefetchable limit, data[15:0]
  - 8: prefetchable upper base, data[31:0]
  - 9: prefetchable upper limit, data[31:0]

  Other codes are ignored. A write affects requests presented from the next cycle on. A request in the same cycle as the write sees the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 4 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Request present this cycle |
| req_io | input | 1 | 1 for I/O space, 0 for memory space |
| req_sec | input | 1 | 1 when the request arrives on the secondary side |
| req_addr | input | 64 | Request address |
| claim_q | output | 1 | Registered claim decision |
| win_q | output | 2 | Registered code of the matching window |

## Verification
The bench aims at the edges of each window:
- **Window boundaries.** It probes the first and last byte inside the window and the bytes just outside it. A design that filled the low bits with the wrong value, or used the wrong relational operator, would then claim one granule too many or too few.
- **Wide and narrow modes.** It runs a wide-mode instance and a narrow-mode instance side by side. A design that let the upper registers leak into 16-bit I/O or 32-bit prefetchable decoding would claim addresses above 64 KB or 4 GB in the narrow instance.
- **Side sense and priority.** A wrong side inversion would flip every secondary-side claim. A wrong priority would report code 3 where memory and prefetchable windows overlap.
- **Register behaviour.** Writes to the read-only nibbles, requests issued in the same cycle as a write, and windows with inverted base and limit catch designs that decode ignored bits, forward written data too early, or treat an empty window as full.

// File: rtl/wfilt_pkg.sv
package wfilt_pkg;

    localparam int ADDR_W = 64;
    localparam int SEL_W  = 4;
    localparam int DATA_W = 32;

    localparam logic [SEL_W-1:0] SEL_MEM_BASE = 4'd0;
    localparam logic [SEL_W-1:0] SEL_MEM_LIM  = 4'd1;
    localparam logic [SEL_W-1:0] SEL_IO_BASE  = 4'd2;
    localparam logic [SEL_W-1:0] SEL_IO_LIM   = 4'd3;
    localparam logic [SEL_W-1:0] SEL_IO_BUP   = 4'd4;
    localparam logic [SEL_W-1:0] SEL_IO_LUP   = 4'd5;
    localparam logic [SEL_W-1:0] SEL_PF_BASE  = 4'd6;
    localparam logic [SEL_W-1:0] SEL_PF_LIM   = 4'd7;
    localparam logic [SEL_W-1:0] SEL_PF_BUP   = 4'd8;
    localparam logic [SEL_W-1:0] SEL_PF_LUP   = 4'd9;

    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_MEM  = 2'd1,
        WIN_IO   = 2'd2,
        WIN_PF   = 2'd3
    } win_code_e;

    typedef struct packed {
        logic [11:0] mem_base;
        logic [11:0] mem_lim;
        logic [3:0]  io_base;
        logic [3:0]  io_lim;
        logic [15:0] io_base_up;
        logic [15:0] io_lim_up;
        logic [11:0] pf_base;
        logic [11:0] pf_lim;
        logic [31:0] pf_base_up;
        logic [31:0] pf_lim_up;
    } cfg_regs_t;

    typedef struct packed {
        logic      claim;
        win_code_e win;
    } decision_t;

endpackage

// File: rtl/wfilt_cfg_regs.sv
module wfilt_cfg_regs
    import wfilt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] wdata,
    output cfg_regs_t         regs
);

    cfg_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we) begin
            unique case (sel)
                SEL_MEM_BASE: regs_d.mem_base   = wdata[15:4];
                SEL_MEM_LIM:  regs_d.mem_lim    = wdata[15:4];
                SEL_IO_BASE:  regs_d.io_base    = wdata[7:4];
                SEL_IO_LIM:   regs_d.io_lim     = wdata[7:4];
                SEL_IO_BUP:   regs_d.io_base_up = wdata[15:0];
                SEL_IO_LUP:   regs_d.io_lim_up  = wdata[15:0];
                SEL_PF_BASE:  regs_d.pf_base    = wdata[15:4];
                SEL_PF_LIM:   regs_d.pf_lim     = wdata[15:4];
                SEL_PF_BUP:   regs_d.pf_base_up = wdata;
                SEL_PF_LUP:   regs_d.pf_lim_up  = wdata;
                default:      regs_d = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.mem_base   <= '1;
            regs_q.mem_lim    <= '0;
            regs_q.io_base    <= '1;
            regs_q.io_lim     <= '0;
            regs_q.io_base_up <= '1;
            regs_q.io_lim_up  <= '0;
            regs_q.pf_base    <= '1;
            regs_q.pf_lim     <= '0;
            regs_q.pf_base_up <= '1;
            regs_q.pf_lim_up  <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign regs = regs_q;

    // R12: a memory base write is visible in the following cycle
    p_mem_base_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == SEL_MEM_BASE) |=> (regs.mem_base == $past(wdata[15:4])));

    // R12: an unmapped select leaves every register untouched
    p_bad_sel_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel > SEL_PF_LUP) |=> $stable(regs));

endmodule

// File: rtl/wfilt_range.sv
module wfilt_range #(
    parameter int W = 64
) (
    input  logic [W-1:0] addr,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    output logic         hit
);
    // An inverted pair (lo > hi) admits no address.
    assign hit = (addr >= lo) && (addr <= hi);
endmodule

// File: rtl/wfilt_decode.sv
module wfilt_decode
    import wfilt_pkg::*;
#(
    parameter bit IO_EN = 1'b1,
    parameter bit IO_32 = 1'b1,
    parameter bit PF_EN = 1'b1,
    parameter bit PF_64 = 1'b1
) (
    input  cfg_regs_t         regs,
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_io,
    output win_code_e         win
);

    localparam int MEM_LOW_W = 20;
    localparam int IO_LOW_W  = 12;

    logic mem_hit, io_hit, pf_hit;
    logic [ADDR_W-1:0] mem_lo, mem_hi;

    assign mem_lo = {32'h0, regs.mem_base, {MEM_LOW_W{1'b0}}};
    assign mem_hi = {32'h0, regs.mem_lim,  {MEM_LOW_W{1'b1}}};

    wfilt_range #(.W(ADDR_W)) u_mem (
        .addr(addr), .lo(mem_lo), .hi(mem_hi), .hit(mem_hit)
    );

    if (IO_EN) begin : g_io
        logic [15:0] up_lo, up_hi;
        logic [ADDR_W-1:0] io_lo, io_hi;
        if (IO_32) begin : g_wide
            assign up_lo = regs.io_base_up;
            assign up_hi = regs.io_lim_up;
        end else begin : g_narrow
            assign up_lo = 16'h0;
            assign up_hi = 16'h0;
        end
        assign io_lo = {32'h0, up_lo, regs.io_base, {IO_LOW_W{1'b0}}};
        assign io_hi = {32'h0, up_hi, regs.io_lim,  {IO_LOW_W{1'b1}}};
        wfilt_range #(.W(ADDR_W)) u_io (
            .addr(addr), .lo(io_lo), .hi(io_hi), .hit(io_hit)
        );
    end else begin : g_no_io
        assign io_hit = 1'b0;
    end

    if (PF_EN) begin : g_pf
        logic [31:0] up_lo, up_hi;
        logic [ADDR_W-1:0] pf_lo, pf_hi;
        if (PF_64) begin : g_wide
            assign up_lo = regs.pf_base_up;
            assign up_hi = regs.pf_lim_up;
        end else begin : g_narrow
            assign up_lo = 32'h0;
            assign up_hi = 32'h0;
        end
        assign pf_lo = {up_lo, regs.pf_base, {MEM_LOW_W{1'b0}}};
        assign pf_hi = {up_hi, regs.pf_lim,  {MEM_LOW_W{1'b1}}};
        wfilt_range #(.W(ADDR_W)) u_pf (
            .addr(addr), .lo(pf_lo), .hi(pf_hi), .hit(pf_hit)
        );
    end else begin : g_no_pf
        assign pf_hit = 1'b0;
    end

    always_comb begin
        win = WIN_NONE;
        if (is_io) begin
            if (io_hit) win = WIN_IO;
        end else if (mem_hit) begin
            win = WIN_MEM;
        end else if (pf_hit) begin
            win = WIN_PF;
        end
    end

endmodule

// File: rtl/bridge_window_filter.sv
module bridge_window_filter
    import wfilt_pkg::*;
#(
    parameter bit IO_EN = 1'b1,
    parameter bit IO_32 = 1'b1,
    parameter bit PF_EN = 1'b1,
    parameter bit PF_64 = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              req_valid,
    input  logic              req_io,
    input  logic              req_sec,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              claim_q,
    output logic [1:0]        win_q
);

    cfg_regs_t regs;
    win_code_e win_c;
    decision_t dec_d, dec_q;

    wfilt_cfg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
        .wdata(cfg_wdata), .regs(regs)
    );

    wfilt_decode #(
        .IO_EN(IO_EN), .IO_32(IO_32), .PF_EN(PF_EN), .PF_64(PF_64)
    ) u_dec (
        .regs(regs), .addr(req_addr), .is_io(req_io), .win(win_c)
    );

    always_comb begin
        dec_d = '{claim: 1'b0, win: WIN_NONE};
        if (req_valid) begin
            dec_d.win   = win_c;
            dec_d.claim = req_sec ? (win_c == WIN_NONE) : (win_c != WIN_NONE);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dec_q <= '{claim: 1'b0, win: WIN_NONE};
        else        dec_q <= dec_d;
    end

    assign claim_q = dec_q.claim;
    assign win_q   = dec_q.win;

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!claim_q && win_q == WIN_NONE));

    p_primary_sense_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_sec) |=> (claim_q == (win_q != WIN_NONE)));

    p_secondary_sense_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_sec) |=> (claim_q == (win_q == WIN_NONE)));

    p_io_space_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_io) |=> (win_q == WIN_NONE || win_q == WIN_IO));

    p_mem_space_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_io) |=> (win_q != WIN_IO));

endmodule

// File: tb/test_bridge_window_filter.sv
module test_bridge_window_filter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_io = 1'b0;
    logic        req_sec = 1'b0;
    logic [63:0] req_addr = '0;
    logic        claim_a, claim_b;
    logic [1:0]  win_a, win_b;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    bridge_window_filter i_bridge_window_filter (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_io(req_io),
        .req_sec(req_sec), .req_addr(req_addr), .claim_q(claim_a), .win_q(win_a)
    );

    bridge_window_filter #(.IO_32(1'b0), .PF_64(1'b0)) i_bridge_window_filter_narrow (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_io(req_io),
        .req_sec(req_sec), .req_addr(req_addr), .claim_q(claim_b), .win_q(win_b)
    );

    // reference register images, reset values per R1
    logic [15:0] m_mem_base = 16'hFFFF, m_mem_lim = 16'h0;
    logic [7:0]  m_io_base = 8'hFF, m_io_lim = 8'h0;
    logic [15:0] m_io_bu = 16'hFFFF, m_io_lu = 16'h0;
    logic [15:0] m_pf_base = 16'hFFFF, m_pf_lim = 16'h0;
    logic [31:0] m_pf_bu = 32'hFFFF_FFFF, m_pf_lu = 32'h0;

    bit    pend = 0;
    string pend_tag;
    logic  e_claim_a, e_claim_b;
    int    e_win_a, e_win_b;

    function automatic int ref_win(logic [63:0] a, logic io, bit wide_io, bit wide_pf);
        logic [63:0] lo, hi;
        if (io) begin
            lo = {32'h0, (wide_io ? m_io_bu : 16'h0), m_io_base[7:4], 12'h000};
            hi = {32'h0, (wide_io ? m_io_lu : 16'h0), m_io_lim[7:4], 12'hFFF};
            return (a >= lo && a <= hi) ? 2 : 0;
        end
        lo = {32'h0, m_mem_base[15:4], 20'h00000};
        hi = {32'h0, m_mem_lim[15:4], 20'hFFFFF};
        if (a >= lo && a <= hi) return 1;
        lo = {(wide_pf ? m_pf_bu : 32'h0), m_pf_base[15:4], 20'h00000};
        hi = {(wide_pf ? m_pf_lu : 32'h0), m_pf_lim[15:4], 20'hFFFFF};
        if (a >= lo && a <= hi) return 3;
        return 0;
    endfunction

    task automatic check(string tag, string who, logic ac, int aw, logic ec, int ew);
        checks++;
        if (ac !== ec || aw != ew) begin
            errors++;
            $display("FAIL %s %s: claim=%0b win=%0d expected claim=%0b win=%0d",
                     tag, who, ac, aw, ec, ew);
        end
    endtask

    task automatic compare_pending();
        if (pend) begin
            check(pend_tag, "wide", claim_a, int'(win_a), e_claim_a, e_win_a);
            check(pend_tag, "narrow", claim_b, int'(win_b), e_claim_b, e_win_b);
        end
        pend = 0;
    endtask

    task automatic step(string tag, logic we, logic [3:0] sel, logic [31:0] wd,
                        logic v, logic io, logic sec, logic [63:0] a);
        @(negedge clk);
        compare_pending();
        cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
        req_valid = v; req_io = io; req_sec = sec; req_addr = a;
        e_win_a = v ? ref_win(a, io, 1'b1, 1'b1) : 0;
        e_win_b = v ? ref_win(a, io, 1'b0, 1'b0) : 0;
        e_claim_a = v && (sec ? (e_win_a == 0) : (e_win_a != 0));
        e_claim_b = v && (sec ? (e_win_b == 0) : (e_win_b != 0));
        pend = 1; pend_tag = tag;
        if (we) begin
            case (sel)
                4'd0: m_mem_base = wd[15:0];
                4'd1: m_mem_lim  = wd[15:0];
                4'd2: m_io_base  = wd[7:0];
                4'd3: m_io_lim   = wd[7:0];
                4'd4: m_io_bu    = wd[15:0];
                4'd5: m_io_lu    = wd[15:0];
                4'd6: m_pf_base  = wd[15:0];
                4'd7: m_pf_lim   = wd[15:0];
                4'd8: m_pf_bu    = wd;
                4'd9: m_pf_lu    = wd;
                default: ;
            endcase
        end
    endtask

    task automatic wr(string tag, logic [3:0] sel, logic [31:0] wd);
        step(tag, 1'b1, sel, wd, 1'b0, 1'b0, 1'b0, 64'h0);
    endtask

    task automatic rq(string tag, logic io, logic sec, logic [63:0] a);
        step(tag, 1'b0, 4'd0, 32'h0, 1'b1, io, sec, a);
    endtask

    task automatic both(string tag, logic io, logic [63:0] a);
        rq(tag, io, 1'b0, a);
        rq(tag, io, 1'b1, a);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "wide", claim_a, int'(win_a), 1'b0, 0);
        check("R1", "narrow", claim_b, int'(win_b), 1'b0, 0);
        rst_n = 1'b1;

        // R1: nothing enabled after reset
        both("R1", 1'b0, 64'h0);
        both("R1", 1'b0, 64'hFFF0_0000);
        both("R1", 1'b1, 64'h0);
        both("R1", 1'b0, 64'hFFFF_FFFF_FFF0_0000);

        // R5 / R12: memory window from the worked example
        wr("R12", 4'd0, 32'h5550);
        wr("R12", 4'd1, 32'h5560);
        both("R5", 1'b0, 64'h5550_0000);
        both("R5", 1'b0, 64'h556F_FFFF);
        both("R5", 1'b0, 64'h554F_FFFF);
        both("R5", 1'b0, 64'h5570_0000);
        both("R5", 1'b0, 64'h1_5550_0000);
        rq("R3", 1'b0, 1'b0, 64'h5560_1234);
        rq("R4", 1'b0, 1'b1, 64'h1000_0000);

        // R12: same-cycle request sees the old limit, the next one the new
        step("R12", 1'b1, 4'd1, 32'h5570, 1'b1, 1'b0, 1'b0, 64'h5570_0000);
        rq("R12", 1'b0, 1'b0, 64'h5570_0000);
        // R12: unmapped select ignored
        wr("R12", 4'd12, 32'h0000_0000);
        rq("R12", 1'b0, 1'b0, 64'h5550_0000);

        // R5: low nibble has no effect
        wr("R5", 4'd0, 32'h555F);
        wr("R5", 4'd1, 32'h5567);
        both("R5", 1'b0, 64'h5550_0000);
        both("R5", 1'b0, 64'h5570_0000);

        // R6 R7 R8: I/O window
        wr("R6", 4'd2, 32'h21);
        wr("R6", 4'd3, 32'h30);
        wr("R7", 4'd4, 32'h0001);
        wr("R7", 4'd5, 32'h0001);
        both("R7", 1'b1, 64'h0001_2000);
        both("R7", 1'b1, 64'h0001_3FFF);
        both("R7", 1'b1, 64'h0001_1FFF);
        both("R7", 1'b1, 64'h0001_4000);
        both("R8", 1'b1, 64'h0000_2000);
        both("R8", 1'b1, 64'h0000_3FFF);
        both("R8", 1'b1, 64'h0000_4000);
        both("R11", 1'b0, 64'h0001_2000);
        wr("R6", 4'd2, 32'h2F);
        wr("R6", 4'd3, 32'h3E);
        both("R6", 1'b1, 64'h0001_2000);
        both("R6", 1'b1, 64'h0000_2000);
        both("R6", 1'b1, 64'h0001_4000);

        // R9: prefetchable window
        wr("R9", 4'd6, 32'h6000);
        wr("R9", 4'd7, 32'h60F0);
        wr("R9", 4'd8, 32'h2);
        wr("R9", 4'd9, 32'h2);
        both("R9", 1'b0, 64'h2_6000_0000);
        both("R9", 1'b0, 64'h2_60FF_FFFF);
        both("R9", 1'b0, 64'h6000_0000);
        both("R9", 1'b0, 64'h2_6100_0000);
        both("R9", 1'b0, 64'h1_6000_0000);
        both("R11", 1'b1, 64'h2_6000_0000);

        // R11: memory wins over prefetchable on overlap
        wr("R11", 4'd8, 32'h0);
        wr("R11", 4'd9, 32'h0);
        wr("R10", 4'd0, 32'h6000);
        wr("R10", 4'd1, 32'h6000);
        both("R11", 1'b0, 64'h6000_0000);
        both("R11", 1'b0, 64'h600F_FFFF);
        both("R11", 1'b0, 64'h6010_0000);

        // R10: inverted windows claim nothing
        wr("R10", 4'd0, 32'h7000);
        wr("R10", 4'd1, 32'h6000);
        both("R10", 1'b0, 64'h6800_0000);
        both("R10", 1'b0, 64'h6000_0000);
        wr("R10", 4'd6, 32'h6100);
        both("R10", 1'b0, 64'h6080_0000);
        wr("R10", 4'd2, 32'h50);
        both("R10", 1'b1, 64'h0001_4000);
        both("R10", 1'b1, 64'h0000_3000);

        // R2: idle cycles inside a live window
        wr("R2", 4'd0, 32'h1000);
        wr("R2", 4'd1, 32'h1FF0);
        step("R2", 1'b0, 4'd0, 32'h0, 1'b0, 1'b0, 1'b0, 64'h1000_0000);
        step("R2", 1'b0, 4'd0, 32'h0, 1'b0, 1'b0, 1'b1, 64'h1000_0000);
        rq("R2", 1'b0, 1'b0, 64'h1000_0000);

        // R3 R4: mixed traffic near window edges
        wr("R3", 4'd2, 32'h20);
        wr("R3", 4'd6, 32'h4000);
        wr("R3", 4'd7, 32'h4800);
        wr("R3", 4'd8, 32'h1);
        wr("R3", 4'd9, 32'h3);
        for (int i = 0; i < 400; i++) begin
            logic [63:0] a;
            logic [2:0]  pick;
            pick = 3'($urandom_range(0, 5));
            case (pick)
                3'd0: a = 64'h1000_0000 + 64'($urandom_range(0, 32'h0020_0000)) - 64'h0010_0000;
                3'd1: a = 64'h1FF0_0000 + 64'($urandom_range(0, 32'h0040_0000)) - 64'h0020_0000;
                3'd2: a = {30'h0, 2'($urandom_range(0, 3)), 32'h4000_0000} + 64'($urandom_range(0, 32'h0FFF_FFFF));
                3'd3: a = {32'h0, 16'($urandom_range(0, 2)), 16'($urandom_range(0, 32'hFFFF))};
                3'd4: a = {32'h0, $urandom};
                default: a = {$urandom, $urandom};
            endcase
            step((i % 2 == 0) ? "R3" : "R4", 1'b0, 4'd0, 32'h0,
                 1'($urandom_range(0, 7) != 0), 1'($urandom_range(0, 1)),
                 1'(i % 2), a);
        end

        step("R2", 1'b0, 4'd0, 32'h0, 1'b0, 1'b0, 1'b0, 64'h0);
        @(negedge clk);
        compare_pending();
        finish_run();
    end

endmodule